// File: doc/BRIEF.md
# Hardware Address Breakpoint Unit

This unit sits beside a processor pipeline and watches two streams: the address of each instruction about to execute, and the address of each data load or store about to reach memory. It holds a control word and two masked compare pairs, one for code and one for data. When an enabled compare hits, it records the kind of hit in sticky flags inside the control word. One cycle later it raises a single-cycle request that the pipeline uses to enter its debug exception.

Software programs the unit through a plain register-write port. A register select of 0 picks the control word, 1 the code address, 2 the code mask, 3 the data address and 4 the data mask. Selects 5 to 7 are ignored.

A compare matches when the address and the reference differ in no bit that the mask keeps. A mask of zero is treated as "disabled" rather than "match everything". Each kind of check needs two master enables plus its own enables. Data stores of the left/right unaligned form are compared on their word-aligned address.

A two-state machine controls the request. It has two states:
- `ST_IDLE`: watching for hits.
- `ST_FIRE`: the request cycle.

It has two transitions:
- `hit_seen`: from `ST_IDLE` to `ST_FIRE`, on any enabled hit.
- `fire_done`: from `ST_FIRE` back to `ST_IDLE`, unconditionally.

Top module: `brkpt_unit`

## Requirements
- R1: After reset the control word and all four compare registers read as zero and `brk_req` is low.
- R2: A write to the control word (select 0) changes only the bits set in 0xFF80F03F. Every other bit keeps its value.
- R3: A code hit needs `ex_valid`, a non-zero code mask, and ((ex_pc XOR code address) AND code mask) equal to zero. A mask of zero never hits.
- R4: Code checks are enabled only while control bits 23, 24 and 31 are all set.
- R5: A data hit needs a non-zero data mask and ((address XOR data address) AND data mask) equal to zero. A read hit also needs control bits 23, 25, 26 and 31 set. A write hit also needs bits 23, 25, 27 and 31 set. When both strobes are high, the access counts as a write.
- R6: A code hit sets control bits 0 (any) and 1 (code). A data hit sets bits 0 and 2 (data), plus bit 3 for a read or bit 4 for a write. These flags are set at the clock edge that ends the hit cycle.
- R7: Status flags stay set until software writes the control word. Accesses that do not hit leave them unchanged.
- R8: When `mem_lr_store` is high, the data compare uses `mem_addr` with its low two bits cleared. Otherwise, loads and stores compare the full `mem_addr`.
- R9: When a code hit and a data hit occur in the same cycle, only the code hit is recorded: bits 0 and 1 are set, and bits 2 to 4 are not.
- R10: `brk_req` is high for exactly the one cycle after a hit cycle. Hits presented during that request cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 ctrl, 1 code addr, 2 code mask, 3 data addr, 4 data mask) |
| cfg_wdata | input | 32 | Register write data |
| ex_valid | input | 1 | An instruction is about to execute |
| ex_pc | input | 32 | Address of that instruction |
| mem_rd | input | 1 | Data load about to be performed |
| mem_wr | input | 1 | Data store about to be performed |
| mem_lr_store | input | 1 | Store is a left/right unaligned form |
| mem_addr | input | 32 | Effective data address |
| brk_req | output | 1 | Single-cycle breakpoint exception request |
| ctrl_q | output | 32 | Control word including status flags |

## Verification
The bench goes after several corner cases:
- **Zero mask.** A design that treated a zero mask as "match all" would fire on every access.
- **Partial enables.** With one enable bit missing, a design that decodes enables loosely would fire anyway. The same applies to a store checked while only reads are enabled.
- **Aligned store address.** A left/right store must hit on its word-aligned address. A plain load at the same unaligned address must not; a design that aligned everything, or nothing, would get one of these wrong.
- **Priority and flags.** A simultaneous code and data hit must leave no data flags. A design that ignored priority would set bits 2 and 3 as well.
- **Pulse width.** A hit held over two cycles must give exactly one request cycle. A design without the request state would stretch the pulse.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    localparam int unsigned CTRL_W = 32;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 32'hFF80_F03F;

    localparam int unsigned EN_MASTER_A = 23;
    localparam int unsigned EN_CODE     = 24;
    localparam int unsigned EN_DATA     = 25;
    localparam int unsigned EN_READ     = 26;
    localparam int unsigned EN_WRITE    = 27;
    localparam int unsigned EN_MASTER_B = 31;

    localparam int unsigned FLAG_W     = 5;
    localparam int unsigned FLAG_ANY   = 0;
    localparam int unsigned FLAG_CODE  = 1;
    localparam int unsigned FLAG_DATA  = 2;
    localparam int unsigned FLAG_READ  = 3;
    localparam int unsigned FLAG_WRITE = 4;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_CADDR = 3'd1,
        SEL_CMASK = 3'd2,
        SEL_DADDR = 3'd3,
        SEL_DMASK = 3'd4
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } bpu_state_e;
endpackage

// File: rtl/bpu_match.sv
module bpu_match #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_addr,
    input  logic [AW-1:0] mask,
    output logic          match
);
    logic [AW-1:0] diff;

    always_comb begin
        diff  = (addr ^ ref_addr) & mask;
        match = (|mask) && (diff == '0);
    end
endmodule

// File: rtl/bpu_regfile.sv
module bpu_regfile
    import bpu_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic [FLAG_W-1:0] set_flags,
    output logic [CTRL_W-1:0] ctrl,
    output logic [AW-1:0]     code_addr,
    output logic [AW-1:0]     code_mask,
    output logic [AW-1:0]     data_addr,
    output logic [AW-1:0]     data_mask
);
    logic [CTRL_W-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl;
        if (cfg_we && cfg_sel == SEL_CTRL)
            ctrl_d = (ctrl & ~CTRL_WMASK) | (cfg_wdata & CTRL_WMASK);
        ctrl_d[FLAG_W-1:0] = ctrl_d[FLAG_W-1:0] | set_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            code_addr <= '0;
            code_mask <= '0;
            data_addr <= '0;
            data_mask <= '0;
        end else begin
            ctrl <= ctrl_d;
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_CADDR: code_addr <= cfg_wdata[AW-1:0];
                    SEL_CMASK: code_mask <= cfg_wdata[AW-1:0];
                    SEL_DADDR: data_addr <= cfg_wdata[AW-1:0];
                    SEL_DMASK: data_mask <= cfg_wdata[AW-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/bpu_ctrl.sv
module bpu_ctrl
    import bpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              ex_valid,
    input  logic              code_match,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              data_match,
    output logic [FLAG_W-1:0] set_flags,
    output logic              brk_req
);
    bpu_state_e state_q, state_d;
    logic master_on, code_on, rd_on, wr_on;
    logic is_write, is_read;
    logic code_hit, data_hit;

    always_comb begin
        master_on = ctrl[EN_MASTER_A] & ctrl[EN_MASTER_B];
        code_on   = master_on & ctrl[EN_CODE];
        rd_on     = master_on & ctrl[EN_DATA] & ctrl[EN_READ];
        wr_on     = master_on & ctrl[EN_DATA] & ctrl[EN_WRITE];
        is_write  = mem_wr;
        is_read   = mem_rd & ~mem_wr;
        code_hit  = ex_valid & code_on & code_match;
        data_hit  = data_match & ((is_read & rd_on) | (is_write & wr_on));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (code_hit || data_hit) state_d = ST_FIRE;
            ST_FIRE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        set_flags = '0;
        brk_req   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (code_hit) begin
                    set_flags[FLAG_ANY]  = 1'b1;
                    set_flags[FLAG_CODE] = 1'b1;
                end else if (data_hit) begin
                    set_flags[FLAG_ANY]   = 1'b1;
                    set_flags[FLAG_DATA]  = 1'b1;
                    set_flags[FLAG_READ]  = is_read;
                    set_flags[FLAG_WRITE] = is_write;
                end
            end
            ST_FIRE: brk_req = 1'b1;
        endcase
    end
endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
    import bpu_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              ex_valid,
    input  logic [AW-1:0]     ex_pc,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              mem_lr_store,
    input  logic [AW-1:0]     mem_addr,
    output logic              brk_req,
    output logic [CTRL_W-1:0] ctrl_q
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN_BITS) - AW'(1));

    logic [AW-1:0]     code_addr_q, code_mask_q, data_addr_q, data_mask_q;
    logic [AW-1:0]     cmp_daddr;
    logic              code_match, data_match;
    logic [FLAG_W-1:0] set_flags;

    assign cmp_daddr = mem_lr_store ? (mem_addr & ALIGN_MASK) : mem_addr;

    bpu_regfile #(.AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .set_flags(set_flags),
        .ctrl(ctrl_q),
        .code_addr(code_addr_q), .code_mask(code_mask_q),
        .data_addr(data_addr_q), .data_mask(data_mask_q)
    );

    bpu_match #(.AW(AW)) code_cmp_i (
        .addr(ex_pc), .ref_addr(code_addr_q), .mask(code_mask_q), .match(code_match)
    );

    bpu_match #(.AW(AW)) data_cmp_i (
        .addr(cmp_daddr), .ref_addr(data_addr_q), .mask(data_mask_q), .match(data_match)
    );

    bpu_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q),
        .ex_valid(ex_valid), .code_match(code_match),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .data_match(data_match),
        .set_flags(set_flags), .brk_req(brk_req)
    );
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker
    import bpu_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_sel,
    input logic              brk_req,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [AW-1:0]     code_mask,
    input logic              code_match
);
    logic ctrl_wr;
    assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);

    assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((ctrl_q ^ $past(ctrl_q)) & ~CTRL_WMASK) == '0));

    assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_mask == '0) |-> !code_match);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ((ctrl_q[FLAG_W-1:0] & $past(ctrl_q[FLAG_W-1:0])) == $past(ctrl_q[FLAG_W-1:0])));

    assert_req_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> ctrl_q[FLAG_ANY]);

    assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req);
endmodule

bind brkpt_unit bpu_checker #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .brk_req(brk_req), .ctrl_q(ctrl_q),
    .code_mask(code_mask_q), .code_match(code_match)
);

// File: tb/brkpt_unit_tb_top.sv
module brkpt_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ex_valid = 1'b0;
    logic [31:0] ex_pc = '0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic        mem_lr_store = 1'b0;
    logic [31:0] mem_addr = '0;
    logic        brk_req;
    logic [31:0] ctrl_q;

    int total = 0;
    int bad = 0;
    logic        got_req;
    logic [31:0] got_ctrl;

    always #2 clk = ~clk;

    brkpt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ex_valid(ex_valid), .ex_pc(ex_pc), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_lr_store(mem_lr_store), .mem_addr(mem_addr),
        .brk_req(brk_req), .ctrl_q(ctrl_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic ev, input logic [31:0] pc, input logic rd,
                         input logic wr, input logic lr, input logic [31:0] addr);
        @(negedge clk);
        ex_valid = ev; ex_pc = pc; mem_rd = rd; mem_wr = wr; mem_lr_store = lr; mem_addr = addr;
        @(negedge clk);
        got_req = brk_req; got_ctrl = ctrl_q;
        ex_valid = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0; mem_lr_store = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 ctrl", ctrl_q, 32'h0);
        check("R1 req", {31'b0, brk_req}, 32'h0);
        probe(1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0);
        check("R1 zero regs no hit", {31'b0, got_req}, 32'h0);
    endtask

    task automatic t_write_mask;
        wr_reg(3'd0, 32'hFFFF_FFFF);
        check("R2 masked write", ctrl_q, 32'hFF80_F03F);
        wr_reg(3'd0, 32'h0);
        check("R2 clear", ctrl_q, 32'h0);
    endtask

    task automatic t_code;
        wr_reg(3'd1, 32'h8000_1000);
        wr_reg(3'd2, 32'hFFFF_F000);
        wr_reg(3'd0, 32'h0180_0000);
        probe(1'b1, 32'h8000_1ABC, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R4 missing master bit31", {31'b0, got_req}, 32'h0);
        wr_reg(3'd0, 32'h8180_0000);
        probe(1'b1, 32'h8000_2000, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R3 code miss", {31'b0, got_req}, 32'h0);
        probe(1'b1, 32'h8000_1ABC, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R3 code hit req", {31'b0, got_req}, 32'h1);
        check("R6 code flags", got_ctrl, 32'h8180_0003);
        probe(1'b1, 32'h8000_2000, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R7 sticky after miss", got_ctrl, 32'h8180_0003);
        wr_reg(3'd0, 32'h8180_0000);
        check("R7 cleared by write", ctrl_q, 32'h8180_0000);
        wr_reg(3'd2, 32'h0);
        probe(1'b1, 32'h8000_1000, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R3 zero mask no hit", {31'b0, got_req}, 32'h0);
    endtask

    task automatic t_data;
        wr_reg(3'd3, 32'h1F80_1000);
        wr_reg(3'd4, 32'hFFFF_FFFC);
        wr_reg(3'd0, 32'h8680_0000);
        probe(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 32'h1F80_1002);
        check("R5 read hit req", {31'b0, got_req}, 32'h1);
        check("R6 read flags", got_ctrl, 32'h8680_000D);
        wr_reg(3'd0, 32'h8680_0000);
        probe(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 32'h1F80_1000);
        check("R5 write w/o write enable", {31'b0, got_req}, 32'h0);
        check("R5 ctrl unchanged", got_ctrl, 32'h8680_0000);
        wr_reg(3'd0, 32'h8A80_0000);
        probe(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 32'h1F80_1001);
        check("R5 write hit req", {31'b0, got_req}, 32'h1);
        check("R6 write flags", got_ctrl, 32'h8A80_0015);
    endtask

    task automatic t_lr_store;
        wr_reg(3'd3, 32'h0000_0100);
        wr_reg(3'd4, 32'hFFFF_FFFF);
        wr_reg(3'd0, 32'h8E80_0000);
        probe(1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 32'h0000_0103);
        check("R8 lr store aligned hit", {31'b0, got_req}, 32'h1);
        check("R8 lr store flags", got_ctrl, 32'h8E80_0015);
        wr_reg(3'd0, 32'h8E80_0000);
        probe(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0000_0103);
        check("R8 load full address miss", {31'b0, got_req}, 32'h0);
        probe(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0000_0103);
        check("R8 plain store full address miss", {31'b0, got_req}, 32'h0);
    endtask

    task automatic t_priority;
        wr_reg(3'd1, 32'h0000_2000);
        wr_reg(3'd2, 32'hFFFF_FFFF);
        wr_reg(3'd3, 32'h0000_3000);
        wr_reg(3'd0, 32'h8780_0000);
        probe(1'b1, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h0000_3000);
        check("R9 both hit req", {31'b0, got_req}, 32'h1);
        check("R9 code-only flags", got_ctrl, 32'h8780_0003);
    endtask

    task automatic t_pulse;
        logic r1, r2;
        wr_reg(3'd0, 32'h8780_0000);
        @(negedge clk);
        check("R10 no req before hit", {31'b0, brk_req}, 32'h0);
        ex_valid = 1'b1; ex_pc = 32'h0000_2000;
        @(negedge clk);
        r1 = brk_req;
        @(negedge clk);
        r2 = brk_req;
        ex_valid = 1'b0;
        check("R10 req first cycle", {31'b0, r1}, 32'h1);
        check("R10 hit in req cycle ignored", {31'b0, r2}, 32'h0);
        @(negedge clk);
        check("R10 stays low", {31'b0, brk_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_mask();
        t_code();
        t_data();
        t_lr_store();
        t_priority();
        t_pulse();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule